// File: doc/BRIEF.md
# Strided Blit Descriptor Chain Builder

This block turns one two-dimensional copy request into a linked chain of four-word transfer descriptors for a scatter-gather copy engine. A request names a system-memory start address, a frame-buffer start address, the bytes per line, the number of lines, a system-memory stride and a signed frame-buffer stride. Every line is cut wherever it would cross a system-memory page. Each resulting piece becomes one descriptor, written one 32-bit word per cycle through a plain memory-write port into descriptor storage.

The chain is linked backwards. The first descriptor written carries only the end-of-chain marker in its link word. Each later descriptor points at the one written before it, and the address of the last one written is reported as the chain head. A caller can first run a count-only pass, which writes nothing and only reports how many descriptors the request needs. It can then run the emit pass. Before any walking starts, the request is checked against size, stride and alignment rules, and a bad request is refused. A request whose lines are contiguous in both memories is folded into one long line.

Top module: `blit_chain_builder`

## Requirements
- R1: A descriptor is four 32-bit words at slot offsets +0, +4, +8 and +12, holding in that order: the system-memory address, the frame-buffer address, the byte size, and the link word. The words are written on consecutive cycles.
- R2: No piece crosses a PAGE_SIZE boundary of system memory. Each piece's size is the smaller of the bytes left to the end of the page and the bytes left in the line. Pieces are emitted in address order.
- R3: After each line, the system address advances by the memory stride and the frame-buffer address by the frame-buffer stride. The frame-buffer stride is a two's-complement value and may be negative.
- R4: The link word of the first descriptor is END_FLAG (default 2, bit 1 set). Each later link word holds the slot address of the descriptor written just before it. When an emit pass completes, chain_head holds the slot address of the last descriptor.
- R5: When the memory stride and the frame-buffer stride both equal the line length, the request is treated as a single line of length line_len*line_cnt. The line-count limit and the alignment rules then apply to that single line.
- R6: A request is refused if line_cnt or line_len is zero, if the effective line count exceeds MAX_LINES (2048), or if line_cnt*mem_stride exceeds MAX_BYTES (16 MiB).
- R7: A request is refused if mem_stride < line_len, if |fb_stride| < line_len, or if mem_stride - line_len exceeds 2*PAGE_SIZE.
- R8: A request is refused if mem_addr is not a multiple of 16 or fb_addr is not a multiple of 4. When there is more than one effective line, it is also refused if mem_stride is not a multiple of 16 or fb_stride is not a multiple of 4.
- R9: With count_only high at start, no write is issued. desc_count ends equal to the emit-pass count, and chain_head stays END_FLAG.
- R10: done is a one-cycle pulse. When done is high, rejected, desc_count and chain_head are valid. A refused request gives rejected=1, desc_count=0, chain_head=END_FLAG and no writes. After reset the block is idle, with desc_count 0 and chain_head END_FLAG.
- R11: Descriptor k is stored at DESC_BASE + (k / (PAGE_SIZE/16)) * DESC_PAGE_STRIDE + (k mod (PAGE_SIZE/16)) * 16.
- R12: start is ignored while busy is high, and the request inputs are sampled only in the cycle start is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Accept a request when idle |
| count_only | input | 1 | 1: count pass, 0: emit pass |
| mem_addr | input | 32 | System-memory start address |
| fb_addr | input | 32 | Frame-buffer start address |
| line_len | input | 32 | Bytes per line |
| line_cnt | input | 32 | Number of lines |
| mem_stride | input | 32 | System-memory line pitch |
| fb_stride | input | 32 | Signed frame-buffer line pitch |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle completion pulse |
| rejected | output | 1 | Request was refused |
| desc_count | output | CNT_W | Descriptors counted or written |
| chain_head | output | 32 | Head pointer of the chain |
| wr_en | output | 1 | Descriptor word write strobe |
| wr_addr | output | 32 | Descriptor word address |
| wr_data | output | 32 | Descriptor word data |

## Verification
The bench uses a 64-byte page so that lines of 8 to 100 bytes at 16-byte offsets split into one, two or three pieces. A design that measured page room from the line start, or let a piece run one byte past the page edge, produces wrong size words. Negative frame-buffer strides catch a design that treats the stride as unsigned, which would send later lines upward in memory. Contiguous requests of more lines than MAX_LINES must be accepted, which catches a checker that applies the line limit before folding. Each limit is probed on both sides: a stride gap of exactly two pages, and exactly MAX_LINES lines. Link words are compared against the previous slot address, and the fifth descriptor falls on a new storage page. This exposes forward linking, an off-by-one in slot numbering, and a design that ignores the storage page stride.

// File: rtl/blit_chain_pkg.sv
// Shared types for the descriptor chain builder.
package blit_chain_pkg;
    // Walker states: idle, cut one piece, write its four words, report.
    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_PIECE = 2'd1,
        S_WRITE = 2'd2,
        S_DONE  = 2'd3
    } walk_state_t;

    // Word index inside a descriptor (the order is consumed by the engine).
    localparam logic [1:0] W_MEM  = 2'd0;
    localparam logic [1:0] W_FB   = 2'd1;
    localparam logic [1:0] W_SIZE = 2'd2;
    localparam logic [1:0] W_LINK = 2'd3;
endpackage

// File: rtl/blit_req_check.sv
// Request checker: folds contiguous requests into one line and decides
// whether the request is acceptable. Purely combinational.
// Assumes PAGE_SIZE is a power of two.
module blit_req_check #(
    parameter int unsigned PAGE_SIZE = 4096,
    parameter int unsigned MAX_LINES = 2048,
    parameter longint unsigned MAX_BYTES = 64'd16777216
) (
    input  logic [3:0]  mem_lo,
    input  logic [1:0]  fb_lo,
    input  logic [31:0] line_len,
    input  logic [31:0] line_cnt,
    input  logic [31:0] mem_stride,
    input  logic [31:0] fb_stride,
    output logic        ok,
    output logic [31:0] eff_len,
    output logic [31:0] eff_lines
);
    localparam logic [31:0] GAP_MAX   = 32'(2 * PAGE_SIZE);
    localparam logic [31:0] LINES_MAX = 32'(MAX_LINES);
    localparam logic [63:0] BYTES_MAX = 64'(MAX_BYTES);

    logic        contig;
    logic [63:0] total;
    logic [32:0] fb_ext, fb_mag;
    logic        bad_zero, bad_stride, bad_gap, bad_size, bad_align;

    // Fold, then evaluate every refusal rule against the folded shape.
    always_comb begin
        contig    = (mem_stride == line_len) && (fb_stride == line_len);
        total     = 64'(line_cnt) * 64'(mem_stride);
        fb_ext    = {fb_stride[31], fb_stride};
        fb_mag    = fb_ext[32] ? (33'd0 - fb_ext) : fb_ext;
        eff_lines = contig ? 32'd1 : line_cnt;
        eff_len   = contig ? total[31:0] : line_len;
        bad_zero  = (line_cnt == 32'd0) || (line_len == 32'd0);
        bad_stride = (mem_stride < line_len) || (fb_mag < {1'b0, line_len});
        bad_gap   = (mem_stride >= line_len) && ((mem_stride - line_len) > GAP_MAX);
        bad_size  = (eff_lines > LINES_MAX) || (total > BYTES_MAX);
        bad_align = (|mem_lo) || (|fb_lo) ||
                    ((eff_lines > 32'd1) && ((|mem_stride[3:0]) || (|fb_stride[1:0])));
        ok = !(bad_zero || bad_stride || bad_gap || bad_size || bad_align);
    end
endmodule

// File: rtl/blit_slot_addr.sv
// Slot address generator: maps a descriptor index to its storage address.
// Storage is split into pages holding PAGE_SIZE/16 descriptors each.
// Assumes PAGE_SIZE >= 32 and a power of two.
module blit_slot_addr #(
    parameter int unsigned CNT_W            = 20,
    parameter int unsigned PAGE_SIZE        = 4096,
    parameter logic [31:0] DESC_BASE        = 32'h0010_0000,
    parameter logic [31:0] DESC_PAGE_STRIDE = 32'h0000_1000
) (
    input  logic [CNT_W-1:0] idx,
    output logic [31:0]      addr
);
    localparam int unsigned SLOTS  = PAGE_SIZE / 16;
    localparam int unsigned SLOT_W = $clog2(SLOTS);

    logic [CNT_W-1:0] page_no;
    logic [31:0]      in_page;

    // Split the index into storage page and slot within page.
    always_comb begin
        page_no = idx >> SLOT_W;
        in_page = 32'({idx[SLOT_W-1:0], 4'b0000});
        addr    = DESC_BASE + 32'(page_no) * DESC_PAGE_STRIDE + in_page;
    end
endmodule

// File: rtl/blit_chain_builder.sv
// Descriptor chain builder top: accepts a strided request, walks it line by
// line cutting pieces at system pages, and writes one four-word descriptor
// per piece, linked backwards. Count-only passes issue no writes.
// Assumes PAGE_SIZE is a power of two >= 32; synchronous active-low reset.
module blit_chain_builder
    import blit_chain_pkg::*;
#(
    parameter int unsigned     CNT_W            = 20,
    parameter int unsigned     PAGE_SIZE        = 4096,
    parameter int unsigned     MAX_LINES        = 2048,
    parameter longint unsigned MAX_BYTES        = 64'd16777216,
    parameter logic [31:0]     DESC_BASE        = 32'h0010_0000,
    parameter logic [31:0]     DESC_PAGE_STRIDE = 32'h0000_1000,
    parameter logic [31:0]     END_FLAG         = 32'h0000_0002
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             count_only,
    input  logic [31:0]      mem_addr,
    input  logic [31:0]      fb_addr,
    input  logic [31:0]      line_len,
    input  logic [31:0]      line_cnt,
    input  logic [31:0]      mem_stride,
    input  logic [31:0]      fb_stride,
    output logic             busy,
    output logic             done,
    output logic             rejected,
    output logic [CNT_W-1:0] desc_count,
    output logic [31:0]      chain_head,
    output logic             wr_en,
    output logic [31:0]      wr_addr,
    output logic [31:0]      wr_data
);
    localparam int unsigned PG_W = $clog2(PAGE_SIZE);

    walk_state_t      state;
    logic             emit, last, rej;
    logic [31:0]      cur_mem, cur_fb, line_mem, line_fb;
    logic [31:0]      ms, fs, len, left, lines_left;
    logic [31:0]      pc_mem, pc_fb, pc_len, head;
    logic [CNT_W-1:0] cnt, pc_idx;
    logic [1:0]       wi;
    logic             req_ok;
    logic [31:0]      eff_len, eff_lines, room, piece, slot;
    logic             line_end;

    blit_req_check #(
        .PAGE_SIZE(PAGE_SIZE), .MAX_LINES(MAX_LINES), .MAX_BYTES(MAX_BYTES)
    ) u_check (
        .mem_lo(mem_addr[3:0]), .fb_lo(fb_addr[1:0]),
        .line_len(line_len), .line_cnt(line_cnt),
        .mem_stride(mem_stride), .fb_stride(fb_stride),
        .ok(req_ok), .eff_len(eff_len), .eff_lines(eff_lines)
    );

    blit_slot_addr #(
        .CNT_W(CNT_W), .PAGE_SIZE(PAGE_SIZE),
        .DESC_BASE(DESC_BASE), .DESC_PAGE_STRIDE(DESC_PAGE_STRIDE)
    ) u_slot (
        .idx(pc_idx), .addr(slot)
    );

    // Size of the next piece: bounded by page room and line remainder.
    always_comb begin
        room     = 32'(PAGE_SIZE) - 32'(cur_mem[PG_W-1:0]);
        piece    = (left < room) ? left : room;
        line_end = (left == piece);
    end

    // Walker state machine: accept, cut pieces, write descriptors, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= S_IDLE;
            emit <= 1'b0; last <= 1'b0; rej <= 1'b0;
            cur_mem <= '0; cur_fb <= '0; line_mem <= '0; line_fb <= '0;
            ms <= '0; fs <= '0; len <= '0; left <= '0; lines_left <= '0;
            pc_mem <= '0; pc_fb <= '0; pc_len <= '0; pc_idx <= '0;
            cnt <= '0; wi <= W_MEM; head <= END_FLAG;
        end else begin
            case (state)
                S_IDLE: if (start) begin
                    rej  <= !req_ok;
                    cnt  <= '0;
                    head <= END_FLAG;
                    emit <= !count_only;
                    cur_mem <= mem_addr; line_mem <= mem_addr;
                    cur_fb  <= fb_addr;  line_fb  <= fb_addr;
                    ms <= mem_stride; fs <= fb_stride;
                    len <= eff_len; left <= eff_len; lines_left <= eff_lines;
                    state <= req_ok ? S_PIECE : S_DONE;
                end
                S_PIECE: begin
                    pc_mem <= cur_mem; pc_fb <= cur_fb; pc_len <= piece;
                    pc_idx <= cnt;
                    cnt    <= cnt + 1'b1;
                    wi     <= W_MEM;
                    last   <= line_end && (lines_left == 32'd1);
                    if (line_end) begin
                        lines_left <= lines_left - 32'd1;
                        line_mem <= line_mem + ms; cur_mem <= line_mem + ms;
                        line_fb  <= line_fb + fs;  cur_fb  <= line_fb + fs;
                        left     <= len;
                    end else begin
                        cur_mem <= cur_mem + piece;
                        cur_fb  <= cur_fb + piece;
                        left    <= left - piece;
                    end
                    if (emit)
                        state <= S_WRITE;
                    else if (line_end && (lines_left == 32'd1))
                        state <= S_DONE;
                end
                S_WRITE: begin
                    wi <= wi + 2'd1;
                    if (wi == W_LINK) begin
                        head  <= slot;
                        state <= last ? S_DONE : S_PIECE;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // Write port: one word of the current descriptor per cycle.
    always_comb begin
        wr_en   = (state == S_WRITE);
        wr_addr = slot + 32'({wi, 2'b00});
        case (wi)
            W_MEM:   wr_data = pc_mem;
            W_FB:    wr_data = pc_fb;
            W_SIZE:  wr_data = pc_len;
            default: wr_data = head;
        endcase
    end

    assign busy       = (state != S_IDLE);
    assign done       = (state == S_DONE);
    assign rejected   = rej;
    assign desc_count = cnt;
    assign chain_head = head;

    // R2: a written piece is non-empty and stays inside one system page.
    a_r2_piece_in_page: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (pc_len != 32'd0) &&
                  ((33'(pc_mem[PG_W-1:0]) + 33'(pc_len)) <= 33'(PAGE_SIZE)));
    // R1: words of one descriptor go to consecutive word addresses.
    a_r1_word_step: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en)) |-> (wr_addr == $past(wr_addr) + 32'd4));
    // R4: the first descriptor closes the chain.
    a_r4_first_link: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wi == W_LINK) && (pc_idx == '0)) |-> (wr_data == END_FLAG));
    // R9: a count pass never writes.
    a_r9_count_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !emit) |-> !wr_en);
    // R10: done lasts one cycle.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: a refused request reports an empty chain.
    a_r10_reject_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rejected) |-> ((desc_count == '0) && (chain_head == END_FLAG)));
endmodule

// File: tb/tb_blit_chain_builder.sv
module tb_blit_chain_builder;
    localparam int unsigned PG   = 64;
    localparam int unsigned MAXL = 6;
    localparam longint unsigned MAXB = 64'd1024;
    localparam logic [31:0] DB   = 32'h0001_0000;
    localparam logic [31:0] DPS  = 32'h0000_0400;
    localparam logic [31:0] ENDF = 32'h0000_0002;
    localparam int unsigned CW   = 20;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, count_only = 1'b0;
    logic [31:0] mem_addr = '0, fb_addr = '0, line_len = '0, line_cnt = '0;
    logic [31:0] mem_stride = '0, fb_stride = '0;
    logic busy, done, rejected, wr_en;
    logic [CW-1:0] desc_count;
    logic [31:0] chain_head, wr_addr, wr_data;

    blit_chain_builder #(
        .CNT_W(CW), .PAGE_SIZE(PG), .MAX_LINES(MAXL), .MAX_BYTES(MAXB),
        .DESC_BASE(DB), .DESC_PAGE_STRIDE(DPS), .END_FLAG(ENDF)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .count_only(count_only),
        .mem_addr(mem_addr), .fb_addr(fb_addr), .line_len(line_len),
        .line_cnt(line_cnt), .mem_stride(mem_stride), .fb_stride(fb_stride),
        .busy(busy), .done(done), .rejected(rejected), .desc_count(desc_count),
        .chain_head(chain_head), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    always #5 clk = ~clk;

    int errors = 0, checks = 0, cycles = 0, cap_n = 0;
    logic [31:0] cap_a [0:4095];
    logic [31:0] cap_d [0:4095];
    logic [31:0] exp_a [0:4095];
    logic [31:0] exp_d [0:4095];
    int exp_n;
    logic exp_ok;
    logic [31:0] exp_head;

    // Capture every write away from the active edge.
    always @(negedge clk) begin
        if (wr_en && cap_n < 4096) begin
            cap_a[cap_n] = wr_addr;
            cap_d[cap_n] = wr_data;
            cap_n = cap_n + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected<150000 cycles", cycles);
            finish_run();
        end
    end

    function automatic logic [31:0] slot_of(input int k);
        return DB + 32'(k / (PG / 16)) * DPS + 32'((k % (PG / 16)) * 16);
    endfunction

    // Arithmetic model of the request rules and the chain contents.
    task automatic model(input logic [31:0] ma, fa, ln, lc, ms, fs);
        logic contig;
        longint tot;
        longint fmag;
        longint lines_e, len_e;
        logic [31:0] lm, lf, cm, cf;
        longint left, room, p;
        int k;
        contig = (ms == ln) && (fs == ln);
        tot = longint'(lc) * longint'(ms);
        fmag = (fs[31]) ? -longint'($signed(fs)) : longint'(fs);
        lines_e = contig ? 1 : longint'(lc);
        len_e = contig ? tot : longint'(ln);
        exp_ok = 1'b1;
        if (lc == 0 || ln == 0) exp_ok = 1'b0;
        if (ms < ln || fmag < longint'(ln)) exp_ok = 1'b0;
        if (ms >= ln && (longint'(ms) - longint'(ln)) > 2 * PG) exp_ok = 1'b0;
        if (lines_e > MAXL || tot > longint'(MAXB)) exp_ok = 1'b0;
        if ((ma % 16) != 0 || (fa % 4) != 0) exp_ok = 1'b0;
        if (lines_e > 1 && ((ms % 16) != 0 || (fs % 4) != 0)) exp_ok = 1'b0;
        exp_n = 0;
        exp_head = ENDF;
        if (!exp_ok) return;
        k = 0; lm = ma; lf = fa;
        for (longint l = 0; l < lines_e; l++) begin
            cm = lm; cf = lf; left = len_e;
            while (left > 0) begin
                room = PG - (cm % PG);
                p = (left < room) ? left : room;
                exp_a[4*k]   = slot_of(k);      exp_d[4*k]   = cm;
                exp_a[4*k+1] = slot_of(k) + 4;  exp_d[4*k+1] = cf;
                exp_a[4*k+2] = slot_of(k) + 8;  exp_d[4*k+2] = 32'(p);
                exp_a[4*k+3] = slot_of(k) + 12;
                exp_d[4*k+3] = (k == 0) ? ENDF : slot_of(k - 1);
                cm = cm + 32'(p); cf = cf + 32'(p); left = left - p;
                k++;
            end
            lm = lm + ms; lf = lf + fs;
        end
        exp_n = k;
        exp_head = slot_of(k - 1);
    endtask

    task automatic drive(input logic [31:0] ma, fa, ln, lc, ms, fs, input logic co);
        mem_addr = ma; fb_addr = fa; line_len = ln; line_cnt = lc;
        mem_stride = ms; fb_stride = fs; count_only = co;
    endtask

    task automatic wait_done(input string tag);
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
        chk({tag, " done reached"}, 64'(done), 64'd1);
    endtask

    // One request end to end; want: 0 accept, 1 refuse, 2 take from model.
    task automatic run_case(input string tag, input logic [31:0] ma, fa, ln, lc, ms,
                            input logic [31:0] fs, input logic co, input int want);
        int base;
        model(ma, fa, ln, lc, ms, fs);
        if (co) exp_head = ENDF;
        drive(ma, fa, ln, lc, ms, fs, co);
        base = cap_n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(tag);
        if (want != 2) chk({tag, " rule outcome"}, 64'(rejected), 64'(want));
        chk({tag, " R10 rejected flag"}, 64'(rejected), 64'(!exp_ok));
        chk({tag, " R10 desc_count"}, 64'(desc_count), 64'(exp_n));
        chk({tag, " R4 chain_head"}, 64'(chain_head), 64'(exp_head));
        if (co || !exp_ok) begin
            chk({tag, " R9 no writes"}, 64'(cap_n - base), 64'd0);
        end else begin
            chk({tag, " R1 word total"}, 64'(cap_n - base), 64'(4 * exp_n));
            for (int i = 0; i < 4 * exp_n && base + i < 4096; i++) begin
                chk({tag, " R11 slot address"}, 64'(cap_a[base + i]), 64'(exp_a[i]));
                case (i % 4)
                    0: chk({tag, " R2 mem word"}, 64'(cap_d[base + i]), 64'(exp_d[i]));
                    1: chk({tag, " R3 fb word"}, 64'(cap_d[base + i]), 64'(exp_d[i]));
                    2: chk({tag, " R2 size word"}, 64'(cap_d[base + i]), 64'(exp_d[i]));
                    default: chk({tag, " R4 link word"}, 64'(cap_d[base + i]), 64'(exp_d[i]));
                endcase
            end
        end
        @(negedge clk);
        chk({tag, " R10 done pulse"}, 64'(done), 64'd0);
        chk({tag, " R10 idle after"}, 64'(busy), 64'd0);
    endtask

    initial begin
        int lens [4] = '{8, 40, 64, 100};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset busy", 64'(busy), 64'd0);
        chk("R10 reset done", 64'(done), 64'd0);
        chk("R10 reset wr_en", 64'(wr_en), 64'd0);
        chk("R10 reset desc_count", 64'(desc_count), 64'd0);
        chk("R10 reset chain_head", 64'(chain_head), 64'(ENDF));

        // Refusal rules and their boundaries.
        run_case("R6 zero lines",  32'h2000, 32'h9000, 32'd8, 32'd0, 32'd16, 32'd8, 1'b0, 1);
        run_case("R6 zero length", 32'h2000, 32'h9000, 32'd0, 32'd2, 32'd16, 32'd8, 1'b0, 1);
        run_case("R6 lines over",  32'h2000, 32'h9000, 32'd8, 32'd7, 32'd16, 32'd8, 1'b0, 1);
        run_case("R6 lines at max", 32'h2000, 32'h9000, 32'd8, 32'd6, 32'd16, 32'd8, 1'b0, 0);
        run_case("R6 bytes over",  32'h2000, 32'h9000, 32'd200, 32'd5, 32'd256, 32'd200, 1'b0, 1);
        run_case("R7 mem stride short", 32'h2000, 32'h9000, 32'd32, 32'd2, 32'd16, 32'd32, 1'b0, 1);
        run_case("R7 fb stride short",  32'h2000, 32'h9000, 32'd32, 32'd2, 32'd32, -32'sd20, 1'b0, 1);
        run_case("R7 gap over",   32'h2000, 32'h9000, 32'd16, 32'd2, 32'd160, 32'd16, 1'b0, 1);
        run_case("R7 gap at max", 32'h2000, 32'h9000, 32'd16, 32'd2, 32'd144, 32'd16, 1'b0, 0);
        run_case("R8 mem misaligned", 32'h2008, 32'h9000, 32'd8, 32'd1, 32'd16, 32'd8, 1'b0, 1);
        run_case("R8 fb misaligned",  32'h2000, 32'h9002, 32'd8, 32'd1, 32'd16, 32'd8, 1'b0, 1);
        run_case("R8 mem stride odd", 32'h2000, 32'h9000, 32'd8, 32'd2, 32'd24, 32'd8, 1'b0, 1);
        run_case("R8 fb stride odd",  32'h2000, 32'h9000, 32'd8, 32'd2, 32'd16, 32'd10, 1'b0, 1);
        run_case("R8 single line any stride", 32'h2000, 32'h9000, 32'd8, 32'd1, 32'd24, 32'd10, 1'b0, 0);

        // Folding of contiguous requests, including more lines than MAX_LINES.
        run_case("R5 fold", 32'h2030, 32'h9000, 32'd16, 32'd5, 32'd16, 32'd16, 1'b0, 0);
        run_case("R5 fold many lines", 32'h2030, 32'h9000, 32'd16, 32'd20, 32'd16, 32'd16, 1'b0, 0);
        run_case("R5 fold count", 32'h2030, 32'h9000, 32'd16, 32'd20, 32'd16, 32'd16, 1'b1, 0);

        // Sweep offsets, lengths, line counts and stride signs, both passes.
        for (int mo = 0; mo < 4; mo++)
            for (int li = 0; li < 4; li++)
                for (int ln = 1; ln <= 3; ln++) begin
                    logic [31:0] l, msv, f4, fsv;
                    l = 32'(lens[li]);
                    msv = ((l + 15) / 16) * 16 + ((ln == 2) ? 32'd16 : 32'd0);
                    f4 = ((l + 3) / 4) * 4;
                    fsv = (ln == 3) ? (32'd0 - f4) : f4;
                    run_case("R3 sweep emit", 32'h2000 + 32'(mo * 16), 32'h8000_0000 + 32'(li * 4),
                             l, 32'(ln), msv, fsv, 1'b0, 0);
                    run_case("R9 sweep count", 32'h2000 + 32'(mo * 16), 32'h8000_0000 + 32'(li * 4),
                             l, 32'(ln), msv, fsv, 1'b1, 0);
                end

        // R12: a second start and changed inputs while busy are ignored.
        begin
            int base;
            model(32'h2010, 32'h9000, 32'd100, 32'd2, 32'd112, 32'd100);
            drive(32'h2010, 32'h9000, 32'd100, 32'd2, 32'd112, 32'd100, 1'b0);
            base = cap_n;
            start = 1'b1;
            @(negedge clk);
            drive(32'h3000, 32'h7000, 32'd8, 32'd1, 32'd16, 32'd8, 1'b1);
            @(negedge clk);
            chk("R12 busy during run", 64'(busy), 64'd1);
            start = 1'b0;
            wait_done("R12");
            chk("R12 count of first request", 64'(desc_count), 64'(exp_n));
            chk("R12 head of first request", 64'(chain_head), 64'(exp_head));
            chk("R12 words of first request", 64'(cap_n - base), 64'(4 * exp_n));
            @(negedge clk);
            @(negedge clk);
            chk("R12 no second run", 64'(busy), 64'd0);
        end

        finish_run();
    end
endmodule